// File: doc/BRIEF.md
# Bus Datapath Mode Steering

This block sits between the transmit and receive FIFOs and a 64-bit external data bus that carries eight byte-enable lines. A configuration register picks one of two ways of using the bus. In the wide mode the whole bus is one bidirectional port. The block drives all data and byte-enable lines only in the cycle that carries write data. In every other cycle it samples data together with the byte-enables that the target drives. In the split mode the upper half of the bus is a transmit-only port and the lower half is a receive-only port. The byte-enable lines are split the same way, so the upper four qualify transmit bytes and the lower four qualify receive bytes.

The block registers transmit data onto the pins and produces the output-enable controls for each half. It also captures receive data for the receive FIFO. Any receive byte whose byte-enable is low reaches the FIFO as zero, and the byte mask travels alongside the data. The mode is meant to be set once. A request to change it while any transfer is in flight is refused, and the refusal is recorded in an error flag that stays set.

Top module: `bus_mode_steer`

## Requirements
- R1: While reset is held and after it is released, the mode is wide (`mode_o`=0). All bits of `bus_oe_o` and `be_oe_o` are 0, and `cfg_err_o` and `rx_wr_o` are 0.
- R2: In wide mode, a cycle with `tx_valid_i`=1 puts `tx_data_i` on `bus_dout_o` and `tx_be_i` on `be_dout_o` in the next cycle. In that cycle `bus_oe_o` and `be_oe_o` are both 2'b11 (bit 1 is the upper half, bit 0 the lower half). In every other wide-mode cycle both are 2'b00.
- R3: In wide mode, a cycle with `rx_valid_i`=1 and the bus not driven makes `rx_wr_o`=1 in the next cycle. In that cycle `rx_mask_o` equals `be_din_i`. Byte k of `rx_data_o` (bits 8k+7..8k) equals byte k of `bus_din_i` where bit k of `be_din_i` is 1, and is zero where it is 0.
- R4: In wide mode, `rx_valid_i` in a cycle where `bus_oe_o` is 2'b11 is ignored, and `rx_wr_o` stays 0 in the next cycle.
- R5: In split mode, a cycle with `tx_valid_i`=1 puts `tx_data_i[31:0]` on `bus_dout_o[63:32]` and `tx_be_i[3:0]` on `be_dout_o[7:4]` in the next cycle. The lower halves of both outputs are zero. In cycles with no transmit, the upper halves are zero as well.
- R6: In split mode, `bus_oe_o` and `be_oe_o` are 2'b10 in every cycle.
- R7: In split mode, `rx_valid_i` is accepted in every cycle, including during transmit. Only `bus_din_i[31:0]` and `be_din_i[3:0]` are used, masked as in R3. `rx_data_o[63:32]` and `rx_mask_o[7:4]` are zero.
- R8: `mode_set_i`=1 in an idle cycle loads `mode_sel_i` (0 wide, 1 split) into `mode_o` in the next cycle.
- R9: `mode_set_i`=1 in a busy cycle leaves `mode_o` unchanged and sets `cfg_err_o` from the next cycle until reset. A cycle is busy when `tx_valid_i` or `rx_valid_i` is 1, or a transmit word is on the pins, or `rx_wr_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_set_i | input | 1 | Mode change request |
| mode_sel_i | input | 1 | Requested mode: 0 wide, 1 split |
| mode_o | output | 1 | Current mode |
| cfg_err_o | output | 1 | Sticky flag for a refused mode change |
| tx_valid_i | input | 1 | Transmit word from the FIFO is valid |
| tx_data_i | input | 64 | Transmit data |
| tx_be_i | input | 8 | Transmit byte mask |
| rx_valid_i | input | 1 | Receive data cycle on the bus |
| rx_wr_o | output | 1 | Write strobe to the receive FIFO |
| rx_data_o | output | 64 | Masked receive data |
| rx_mask_o | output | 8 | Receive byte mask |
| bus_din_i | input | 64 | Data sampled from the bus pins |
| bus_dout_o | output | 64 | Data driven toward the bus pins |
| bus_oe_o | output | 2 | Data output enable per half, bit 1 upper |
| be_din_i | input | 8 | Byte-enables sampled from the pins |
| be_dout_o | output | 8 | Byte-enables driven toward the pins |
| be_oe_o | output | 2 | Byte-enable output enable per half, bit 1 upper |

## Verification
A corrupted mode register shows up at once on the enables: split mode forces 2'b10 on every cycle, while wide mode shows 2'b00 when idle. A stuck transmit stage would leave the wide-mode enables high one cycle too long. That would also suppress the next receive strobe, so `rx_wr_o` would be missing one cycle later. Wrong lane masking or half selection in the receive capture shows in the first `rx_wr_o` pulse after the strobe, as a nonzero byte under a cleared mask bit or as data in the upper half during split mode. A missing busy term shows as a mode flip or an unset `cfg_err_o` in the cycle after the refused request.

// File: rtl/bus_steer_pkg.sv
package bus_steer_pkg;
  typedef enum logic {
    MODE_WIDE  = 1'b0,
    MODE_SPLIT = 1'b1
  } bus_mode_e;
endpackage

// File: rtl/steer_mode_ctrl.sv
module steer_mode_ctrl
  import bus_steer_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      set_i,
  input  logic      sel_i,
  input  logic      busy_i,
  output bus_mode_e mode_o,
  output logic      err_o
);
  bus_mode_e mode_q;
  logic      err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_WIDE;
      err_q  <= 1'b0;
    end else if (set_i) begin
      if (busy_i) err_q  <= 1'b1;
      else        mode_q <= bus_mode_e'(sel_i);
    end
  end

  assign mode_o = mode_q;
  assign err_o  = err_q;

  p_hold_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && busy_i) |=> ($stable(mode_q) && err_q));
  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  p_idle_apply_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !busy_i) |=> (mode_q == bus_mode_e'($past(sel_i))));
endmodule

// File: rtl/steer_tx_path.sv
module steer_tx_path
  import bus_steer_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  bus_mode_e           mode_i,
  input  logic                tx_valid_i,
  input  logic [DATA_W-1:0]   tx_data_i,
  input  logic [DATA_W/8-1:0] tx_be_i,
  output logic [DATA_W-1:0]   dout_o,
  output logic [DATA_W/8-1:0] be_o,
  output logic [1:0]          dout_oe_o,
  output logic [1:0]          be_oe_o,
  output logic                active_o
);
  localparam int NB   = DATA_W / 8;
  localparam int HALF = DATA_W / 2;
  localparam int HB   = NB / 2;

  logic [DATA_W-1:0] nxt_data, data_q;
  logic [NB-1:0]     nxt_be, be_q;
  logic              act_q;

  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam bit UPPER = (h == 1);
    // split mode: low FIFO half rides on the upper pins, lower pins idle
    assign nxt_data[h*HALF +: HALF] = !tx_valid_i ? '0 :
      (mode_i == MODE_WIDE) ? tx_data_i[h*HALF +: HALF] :
      (UPPER ? tx_data_i[HALF-1:0] : '0);
    assign nxt_be[h*HB +: HB] = !tx_valid_i ? '0 :
      (mode_i == MODE_WIDE) ? tx_be_i[h*HB +: HB] :
      (UPPER ? tx_be_i[HB-1:0] : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      data_q <= '0;
      be_q   <= '0;
    end else begin
      act_q  <= tx_valid_i;
      data_q <= nxt_data;
      be_q   <= nxt_be;
    end
  end

  always_comb begin
    if (mode_i == MODE_SPLIT) begin
      dout_oe_o = 2'b10;
      be_oe_o   = 2'b10;
    end else begin
      dout_oe_o = {2{act_q}};
      be_oe_o   = {2{act_q}};
    end
  end

  assign dout_o   = data_q;
  assign be_o     = be_q;
  assign active_o = act_q;

  p_wide_drive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && mode_i == MODE_WIDE) |=> (dout_oe_o == 2'b11 && be_oe_o == 2'b11));
  p_split_low_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_SPLIT && !act_q) |-> (dout_o == '0 && be_o == '0));
endmodule

// File: rtl/steer_rx_path.sv
module steer_rx_path
  import bus_steer_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  bus_mode_e           mode_i,
  input  logic                rx_valid_i,
  input  logic                drive_act_i,
  input  logic [DATA_W-1:0]   din_i,
  input  logic [DATA_W/8-1:0] be_i,
  output logic                wr_o,
  output logic [DATA_W-1:0]   data_o,
  output logic [DATA_W/8-1:0] mask_o
);
  localparam int NB   = DATA_W / 8;
  localparam int HALF = DATA_W / 2;
  localparam int HB   = NB / 2;

  logic [NB-1:0]     lane_en, mask_q;
  logic [DATA_W-1:0] nxt_data, data_q;
  logic              accept, wr_q;

  // wide mode: bus owned by a write this cycle, no sample
  assign accept = rx_valid_i && !(mode_i == MODE_WIDE && drive_act_i);

  for (genvar b = 0; b < NB; b++) begin : g_lane
    localparam bit RX_LANE = (b < HB);
    assign lane_en[b] = be_i[b] && (mode_i == MODE_WIDE || RX_LANE);
    assign nxt_data[8*b +: 8] = lane_en[b] ? din_i[8*b +: 8] : 8'h00;

    p_zero_lane_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_q && !mask_q[b]) |-> (data_q[8*b +: 8] == 8'h00));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b0;
      data_q <= '0;
      mask_q <= '0;
    end else begin
      wr_q <= accept;
      if (accept) begin
        data_q <= nxt_data;
        mask_q <= lane_en;
      end
    end
  end

  assign wr_o   = wr_q;
  assign data_o = data_q;
  assign mask_o = mask_q;

  p_conflict_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && mode_i == MODE_WIDE && drive_act_i) |=> !wr_q);
  p_split_upper_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_q && mode_i == MODE_SPLIT) |-> (mask_q[NB-1:HB] == '0 && data_q[DATA_W-1:HALF] == '0));
endmodule

// File: rtl/bus_mode_steer.sv
module bus_mode_steer
  import bus_steer_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mode_set_i,
  input  logic                mode_sel_i,
  output logic                mode_o,
  output logic                cfg_err_o,
  input  logic                tx_valid_i,
  input  logic [DATA_W-1:0]   tx_data_i,
  input  logic [DATA_W/8-1:0] tx_be_i,
  input  logic                rx_valid_i,
  output logic                rx_wr_o,
  output logic [DATA_W-1:0]   rx_data_o,
  output logic [DATA_W/8-1:0] rx_mask_o,
  input  logic [DATA_W-1:0]   bus_din_i,
  output logic [DATA_W-1:0]   bus_dout_o,
  output logic [1:0]          bus_oe_o,
  input  logic [DATA_W/8-1:0] be_din_i,
  output logic [DATA_W/8-1:0] be_dout_o,
  output logic [1:0]          be_oe_o
);
  bus_mode_e mode;
  logic      tx_act, busy;

  assign busy = tx_valid_i | rx_valid_i | tx_act | rx_wr_o;

  steer_mode_ctrl u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (mode_set_i),
    .sel_i  (mode_sel_i),
    .busy_i (busy),
    .mode_o (mode),
    .err_o  (cfg_err_o)
  );

  steer_tx_path #(.DATA_W(DATA_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .tx_valid_i (tx_valid_i),
    .tx_data_i  (tx_data_i),
    .tx_be_i    (tx_be_i),
    .dout_o     (bus_dout_o),
    .be_o       (be_dout_o),
    .dout_oe_o  (bus_oe_o),
    .be_oe_o    (be_oe_o),
    .active_o   (tx_act)
  );

  steer_rx_path #(.DATA_W(DATA_W)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .rx_valid_i  (rx_valid_i),
    .drive_act_i (tx_act),
    .din_i       (bus_din_i),
    .be_i        (be_din_i),
    .wr_o        (rx_wr_o),
    .data_o      (rx_data_o),
    .mask_o      (rx_mask_o)
  );

  assign mode_o = mode;

  p_split_oe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_SPLIT) |-> (bus_oe_o == 2'b10 && be_oe_o == 2'b10));
  p_wide_idle_oe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_WIDE && !tx_act) |-> (bus_oe_o == 2'b00 && be_oe_o == 2'b00));
  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!rx_wr_o && !cfg_err_o && mode == MODE_WIDE));
endmodule

// File: tb/bus_mode_steer_bench.sv
module bus_mode_steer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_set = 1'b0, mode_sel = 1'b0;
  logic        mode, cfg_err;
  logic        tx_valid = 1'b0;
  logic [63:0] tx_data = '0;
  logic [7:0]  tx_be = '0;
  logic        rx_valid = 1'b0;
  logic        rx_wr;
  logic [63:0] rx_data;
  logic [7:0]  rx_mask;
  logic [63:0] bus_din = '0, bus_dout;
  logic [1:0]  bus_oe, be_oe;
  logic [7:0]  be_din = '0, be_dout;

  int checks = 0, failures = 0;
  bit split_m = 1'b0;
  bit done = 1'b0;
  logic [63:0] exp_data_q[$];
  logic [7:0]  exp_mask_q[$];

  always #10 clk = ~clk;

  bus_mode_steer u_bus_mode_steer (
    .clk_i(clk), .rst_ni(rst_n),
    .mode_set_i(mode_set), .mode_sel_i(mode_sel),
    .mode_o(mode), .cfg_err_o(cfg_err),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_be_i(tx_be),
    .rx_valid_i(rx_valid), .rx_wr_o(rx_wr), .rx_data_o(rx_data), .rx_mask_o(rx_mask),
    .bus_din_i(bus_din), .bus_dout_o(bus_dout), .bus_oe_o(bus_oe),
    .be_din_i(be_din), .be_dout_o(be_dout), .be_oe_o(be_oe)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tx_cycle(input logic [63:0] d, input logic [7:0] be);
    tx_valid = 1'b1; tx_data = d; tx_be = be;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // expected receive word built from the masking rule, per mode
  task automatic push_rx(input logic [63:0] din, input logic [7:0] be);
    logic [63:0] d = '0;
    logic [7:0]  m = '0;
    for (int b = 0; b < 8; b++) begin
      if (be[b] && (!split_m || b < 4)) begin
        m[b] = 1'b1;
        d[8*b +: 8] = din[8*b +: 8];
      end
    end
    exp_data_q.push_back(d);
    exp_mask_q.push_back(m);
  endtask

  task automatic rx_cycle(input logic [63:0] din, input logic [7:0] be);
    push_rx(din, be);
    rx_valid = 1'b1; bus_din = din; be_din = be;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // monitor: every receive strobe must match the oldest expected word (R3, R7)
  always @(negedge clk) begin
    if (rst_n && rx_wr) begin
      if (exp_data_q.size() == 0) begin
        check(1'b0, "R4 unexpected rx write", {56'd0, rx_mask}, 64'd0);
      end else begin
        logic [63:0] ed;
        logic [7:0]  em;
        ed = exp_data_q.pop_front();
        em = exp_mask_q.pop_front();
        check(rx_data == ed, "R3/R7 rx data", rx_data, ed);
        check(rx_mask == em, "R3/R7 rx mask", {56'd0, rx_mask}, {56'd0, em});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check(bus_oe == 2'b00 && be_oe == 2'b00, "R1 oe in reset", {60'd0, bus_oe, be_oe}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(mode == 1'b0 && cfg_err == 1'b0 && rx_wr == 1'b0, "R1 state after reset",
          {61'd0, mode, cfg_err, rx_wr}, 64'd0);
    check(bus_oe == 2'b00 && be_oe == 2'b00, "R1 oe after reset", {60'd0, bus_oe, be_oe}, 64'd0);

    // wide transmit
    tx_cycle(64'h0123_4567_89AB_CDEF, 8'hFF);
    check(bus_dout == 64'h0123_4567_89AB_CDEF, "R2 wide dout", bus_dout, 64'h0123_4567_89AB_CDEF);
    check(be_dout == 8'hFF && bus_oe == 2'b11 && be_oe == 2'b11, "R2 wide be/oe",
          {52'd0, be_dout, bus_oe, be_oe}, {52'd0, 8'hFF, 4'hF});
    tx_cycle(64'hDEAD_BEEF_0BAD_F00D, 8'h3C);
    check(bus_dout == 64'hDEAD_BEEF_0BAD_F00D && be_dout == 8'h3C, "R2 wide second word",
          bus_dout ^ {56'd0, be_dout}, 64'hDEAD_BEEF_0BAD_F00D ^ 64'h3C);
    @(negedge clk);
    check(bus_oe == 2'b00 && be_oe == 2'b00, "R2 wide idle oe", {60'd0, bus_oe, be_oe}, 64'd0);

    // wide receive, several byte masks
    rx_cycle(64'hA1A2_A3A4_A5A6_A7A8, 8'hFF);
    rx_cycle(64'h1122_3344_5566_7788, 8'h5A);
    rx_cycle(64'hFFFF_FFFF_FFFF_FFFF, 8'h00);
    rx_cycle(64'h0F1E_2D3C_4B5A_6978, 8'h81);
    @(negedge clk);

    // R4: receive strobe while a write owns the bus
    tx_valid = 1'b1; tx_data = 64'h5555_AAAA_5555_AAAA; tx_be = 8'hFF;
    @(negedge clk);
    tx_valid = 1'b0;
    check(bus_oe == 2'b11, "R4 bus driven", {62'd0, bus_oe}, 64'd3);
    rx_valid = 1'b1; bus_din = 64'h1234; be_din = 8'hFF;
    @(negedge clk);
    rx_valid = 1'b0;
    check(rx_wr == 1'b0, "R4 conflict dropped", {63'd0, rx_wr}, 64'd0);
    repeat (2) @(negedge clk);

    // R8: idle switch to split
    mode_set = 1'b1; mode_sel = 1'b1;
    @(negedge clk);
    mode_set = 1'b0;
    split_m = 1'b1;
    check(mode == 1'b1 && cfg_err == 1'b0, "R8 switch to split", {62'd0, mode, cfg_err}, 64'd2);
    check(bus_oe == 2'b10 && be_oe == 2'b10, "R6 split idle oe", {60'd0, bus_oe, be_oe}, {60'd0, 4'b1010});
    check(bus_dout == 64'd0 && be_dout == 8'd0, "R5 split idle pins", bus_dout, 64'd0);

    // split transmit
    tx_cycle(64'h1111_2222_3333_4444, 8'hF6);
    check(bus_dout == 64'h3333_4444_0000_0000, "R5 split dout", bus_dout, 64'h3333_4444_0000_0000);
    check(be_dout == 8'h60, "R5 split be", {56'd0, be_dout}, 64'h60);
    check(bus_oe == 2'b10 && be_oe == 2'b10, "R6 split tx oe", {60'd0, bus_oe, be_oe}, {60'd0, 4'b1010});

    // split receive: upper pins ignored
    rx_cycle(64'h9988_7766_5544_3322, 8'hFF);
    rx_cycle(64'hCAFE_BABE_1357_9BDF, 8'hA5);

    // R9: busy request refused while tx and rx run together (R7 concurrency)
    tx_valid = 1'b1; tx_data = 64'h0000_0000_F0E1_D2C3; tx_be = 8'h0F;
    push_rx(64'h7777_7777_0102_0304, 8'hFF);
    rx_valid = 1'b1; bus_din = 64'h7777_7777_0102_0304; be_din = 8'hFF;
    mode_set = 1'b1; mode_sel = 1'b0;
    @(negedge clk);
    tx_valid = 1'b0; rx_valid = 1'b0; mode_set = 1'b0;
    check(mode == 1'b1, "R9 mode kept", {63'd0, mode}, 64'd1);
    check(cfg_err == 1'b1, "R9 error set", {63'd0, cfg_err}, 64'd1);
    check(bus_dout == 64'hF0E1_D2C3_0000_0000 && be_dout == 8'hF0, "R5 split tx during rx",
          bus_dout, 64'hF0E1_D2C3_0000_0000);
    repeat (3) @(negedge clk);
    check(cfg_err == 1'b1, "R9 error sticky", {63'd0, cfg_err}, 64'd1);

    // R8: idle switch back to wide
    mode_set = 1'b1; mode_sel = 1'b0;
    @(negedge clk);
    mode_set = 1'b0;
    split_m = 1'b0;
    check(mode == 1'b0, "R8 switch to wide", {63'd0, mode}, 64'd0);
    check(cfg_err == 1'b1, "R9 error survives change", {63'd0, cfg_err}, 64'd1);
    check(bus_oe == 2'b00 && be_oe == 2'b00, "R2 wide idle after return", {60'd0, bus_oe, be_oe}, 64'd0);
    rx_cycle(64'h8899_AABB_CCDD_EEFF, 8'hF0);
    repeat (3) @(negedge clk);
    check(exp_data_q.size() == 0, "R3/R7 all rx words seen", 64'(exp_data_q.size()), 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule